// File: doc/BRIEF.md
# Half-duplex single-data-line SPI transaction master

This block runs complete transactions on a three-wire serial bus: a clock, an active-low chip select and one data line that carries traffic in both directions. A host hands over one request at a time. The request holds a direction, an address-increment flag, a two-bit function number, a 17-bit address and an 11-bit byte count. The block packs these fields into a 32-bit command word and shifts it out most significant bit first. On a write it then sends the payload bytes. On a read it releases the data line and samples the payload. Every payload is rounded up to whole 32-bit words.

Payload bytes move through valid/ready byte streams. The engine works one 32-bit word at a time. It gathers four write bytes before shifting a word and hands out four read bytes after a word has been shifted in. While a stream is not ready, the bus clock is held low. Reads from function 1 carry one extra 32-bit word of bus turnaround, which is clocked in and dropped. A per-request swap flag exchanges the two bytes within each 16-bit half of every word on the wire, for links whose word order is not yet configured. The half-period of the bus clock is an input that is latched with each request.

Top module: `spi3w_txn_master`

## Requirements
- R1: The command word is {write, increment, function[1:0], address[16:0], length[10:0]}, with write in bit 31 and length in bits 10:0. Its bits go onto bus_dout starting with bit 31, one bit per bus clock period.
- R2: bus_dout changes only while bus_sck is low. bus_din is sampled on the system clock edge at which bus_sck rises.
- R3: On a write, payload bytes are sent in stream order, each most significant bit first. After the last byte, zero bytes are sent up to the next multiple of 4 bytes, and bus_oe stays high through them.
- R4: On a read, bus_oe drops after the 32nd command bit. The bytes sampled from bus_din are delivered on rd_data in wire order. Exactly the requested number of bytes is delivered, and the padding bytes that complete the last word are dropped.
- R5: A read with function code 1 clocks in 32 extra bits between the command word and the data, and discards them.
- R6: With req_swap set, the command word and every payload word on the wire have the two bytes of each 16-bit half exchanged: logical bytes B3 B2 B1 B0 appear on the wire as B2 B3 B0 B1.
- R7: bus_cs_n stays low from the request until the last bit. At its rising edge bus_sck is low, and bus_oe is low whenever bus_cs_n is high. bus_sck pulses only while bus_cs_n is low.
- R8: Each half of a bus clock period lasts half_period system clocks, and a value of 0 counts as 1. The first rising edge of bus_sck comes one half-period after bus_cs_n falls. bus_cs_n stays high for at least one half-period between transactions.
- R9: While wr_ready is high with wr_valid low, or rd_valid is high with rd_ready low, bus_sck stays low and does not toggle.
- R10: done is a one-cycle pulse in the cycle bus_cs_n rises. req_ready is high only when busy is low.
- R11: While rst_n is low, and in the cycle after it goes low, bus_cs_n is high, bus_sck and bus_oe are low, and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_period | input | DIV_W | Bus clock half-period in system clocks, latched at request |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_incr | input | 1 | Address increment flag placed in the command |
| req_func | input | 2 | Function number |
| req_addr | input | 17 | Address field |
| req_len | input | 11 | Payload byte count |
| req_swap | input | 1 | Exchange bytes within 16-bit halves |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken when high with wr_valid |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken when high with rd_valid |
| busy | output | 1 | Transaction in progress, including the closing gap |
| done | output | 1 | One-cycle end-of-transaction pulse |
| bus_sck | output | 1 | Bus clock |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_dout | output | 1 | Data driven onto the shared line |
| bus_oe | output | 1 | Drive enable for the shared line |
| bus_din | input | 1 | Data seen on the shared line |

## Verification
The hardest case to reach is a read from function 1 whose length is not a multiple of four, with the consumer stalling in the middle of a word. That case needs the discarded turnaround word, the dropped padding bytes and the held clock at once. The vector table includes such a read with rd_ready toggled every other cycle and a half-period of three, and a write with both padding and a throttled producer. A bus model in the bench serves a deterministic bit pattern indexed by bit position since chip select fell. Every expected byte, including those behind the turnaround word and the swap, is derived from that pattern.

// File: rtl/spi3w_pkg.sv
// Shared constants, state encoding and word helpers for the three-wire
// transaction master. Assumes the fixed 32-bit command layout.
package spi3w_pkg;

    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 17;
    localparam int LEN_W    = 11;
    localparam int FN_W     = 2;
    localparam int BITCNT_W = $clog2(WORD_W);
    localparam int BSEL_W   = $clog2(WORD_W / BYTE_W);

    // function number whose reads carry one turnaround word
    localparam logic [FN_W-1:0] FN_BACKPLANE = 2'd1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_FILL,
        ST_WBITS,
        ST_DELAY,
        ST_RBITS,
        ST_DRAIN,
        ST_TAIL,
        ST_GAP
    } xfer_state_t;

    // exchange the two bytes inside each 16-bit half
    function automatic logic [WORD_W-1:0] half_swap(input logic [WORD_W-1:0] x);
        return {x[23:16], x[31:24], x[7:0], x[15:8]};
    endfunction

    // pack request fields into the command word
    function automatic logic [WORD_W-1:0] build_cmd(
        input logic              wr,
        input logic              inc,
        input logic [FN_W-1:0]   fn,
        input logic [ADDR_W-1:0] addr,
        input logic [LEN_W-1:0]  len
    );
        return {wr, inc, fn, addr, len};
    endfunction

endpackage

// File: rtl/spi3w_half_timer.sv
// Half-period tick generator. Counts system clocks while run is high and
// pulses tick on the last clock of each half-period. Assumes half_len >= 1.
module spi3w_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_len,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == half_len - 1'b1);

    // count within the current half-period; restart when stopped or at tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi3w_word_shifter.sv
// Word-wide shift register: parallel load, left shift with serial input.
// The MSB is the outgoing serial bit. Assumes load and shift are exclusive.
module spi3w_word_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    input  logic              shift_in,
    output logic [WORD_W-1:0] word,
    output logic              msb
);

    logic [WORD_W-1:0] sreg;

    assign word = sreg;
    assign msb  = sreg[WORD_W-1];

    // hold, load or shift the word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= load_word;
        end else if (shift) begin
            sreg <= {sreg[WORD_W-2:0], shift_in};
        end
    end

endmodule

// File: rtl/spi3w_txn_master.sv
// Transaction master for a three-wire bus with one shared data line.
// It sends a packed command word, then sends or samples a payload padded
// to whole 32-bit words. The bus clock stops low while a byte stream stalls.
// Assumes one request at a time and an external tri-state buffer driven by
// bus_dout/bus_oe.
module spi3w_txn_master
    import spi3w_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    half_period,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic                req_incr,
    input  logic [FN_W-1:0]     req_func,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [LEN_W-1:0]    req_len,
    input  logic                req_swap,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                wr_valid,
    output logic                wr_ready,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                rd_valid,
    input  logic                rd_ready,
    output logic                busy,
    output logic                done,
    output logic                bus_sck,
    output logic                bus_cs_n,
    output logic                bus_dout,
    output logic                bus_oe,
    input  logic                bus_din
);

    localparam logic [BITCNT_W-1:0] LAST_BIT  = BITCNT_W'(WORD_W - 1);
    localparam logic [BSEL_W-1:0]   LAST_BYTE = BSEL_W'(WORD_W / BYTE_W - 1);

    xfer_state_t         state;
    logic                sck_q, cs_n_q, oe_q, done_q, sbit;
    logic                is_write, is_swap, is_bp;
    logic [DIV_W-1:0]    hp_q;
    logic [LEN_W-1:0]    bytes_left;
    logic [BSEL_W-1:0]   bidx;
    logic [BITCNT_W-1:0] bitcnt;
    logic [WORD_W-1:0]   acc;

    logic                tick, timer_run, shift_state;
    logic                rise_pt, fall_pt, have_bytes, accept;
    logic                fill_take, drain_step, sh_load;
    logic [BYTE_W-1:0]   fill_byte;
    logic [WORD_W-1:0]   fill_word, rd_word, sh_word, sh_load_word, cmd_word;
    logic                sh_msb;
    logic [4:0]          byte_sel;

    // which states run the bus clock or wait on the timer
    assign shift_state = (state == ST_CMD) || (state == ST_WBITS) ||
                         (state == ST_DELAY) || (state == ST_RBITS);
    assign timer_run   = shift_state || (state == ST_TAIL) || (state == ST_GAP);
    assign rise_pt     = tick && shift_state && !sck_q;
    assign fall_pt     = tick && shift_state && sck_q;
    assign have_bytes  = (bytes_left != '0);
    assign accept      = (state == ST_IDLE) && req_valid;

    // byte lane of the current word, first byte in the top lane
    assign byte_sel = {~bidx, 3'b000};

    // write gathering: real byte while payload remains, zero for padding
    assign fill_byte = have_bytes ? wr_data : '0;
    assign fill_take = (state == ST_FILL) && (!have_bytes || wr_valid);
    always_comb begin
        fill_word                  = acc;
        fill_word[byte_sel +: 8]   = fill_byte;
    end

    // read draining: hand out real bytes, drop padding silently
    assign rd_word    = is_swap ? half_swap(sh_word) : sh_word;
    assign rd_data    = rd_word[byte_sel +: 8];
    assign rd_valid   = (state == ST_DRAIN) && have_bytes;
    assign drain_step = (state == ST_DRAIN) && (!have_bytes || rd_ready);

    // shifter load at request (command) or when a write word is complete
    assign cmd_word     = build_cmd(req_write, req_incr, req_func, req_addr, req_len);
    assign sh_load      = accept || (fill_take && (bidx == LAST_BYTE));
    assign sh_load_word = accept ? (req_swap ? half_swap(cmd_word) : cmd_word)
                                 : (is_swap ? half_swap(fill_word) : fill_word);

    spi3w_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (timer_run),
        .half_len (hp_q),
        .tick     (tick)
    );

    spi3w_word_shifter #(.WORD_W(WORD_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_word (sh_load_word),
        .shift     (fall_pt),
        .shift_in  (sbit),
        .word      (sh_word),
        .msb       (sh_msb)
    );

    // transaction sequencing, bus pins and byte bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            sck_q      <= 1'b0;
            cs_n_q     <= 1'b1;
            oe_q       <= 1'b0;
            done_q     <= 1'b0;
            sbit       <= 1'b0;
            is_write   <= 1'b0;
            is_swap    <= 1'b0;
            is_bp      <= 1'b0;
            hp_q       <= DIV_W'(1);
            bytes_left <= '0;
            bidx       <= '0;
            bitcnt     <= '0;
            acc        <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        is_write   <= req_write;
                        is_swap    <= req_swap;
                        is_bp      <= (req_func == FN_BACKPLANE);
                        hp_q       <= (half_period == '0) ? DIV_W'(1) : half_period;
                        bytes_left <= req_len;
                        bidx       <= '0;
                        bitcnt     <= '0;
                        sck_q      <= 1'b0;
                        cs_n_q     <= 1'b0;
                        oe_q       <= 1'b1;
                        state      <= ST_CMD;
                    end
                end
                ST_CMD, ST_WBITS, ST_DELAY, ST_RBITS: begin
                    if (rise_pt) begin
                        sck_q <= 1'b1;
                        sbit  <= bus_din;
                    end
                    if (fall_pt) begin
                        sck_q  <= 1'b0;
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == LAST_BIT) begin
                            case (state)
                                ST_CMD: begin
                                    if (is_write) begin
                                        state <= have_bytes ? ST_FILL : ST_TAIL;
                                    end else begin
                                        oe_q  <= 1'b0;
                                        state <= is_bp ? ST_DELAY
                                               : (have_bytes ? ST_RBITS : ST_TAIL);
                                    end
                                end
                                ST_WBITS: state <= have_bytes ? ST_FILL : ST_TAIL;
                                ST_DELAY: state <= have_bytes ? ST_RBITS : ST_TAIL;
                                default:  state <= ST_DRAIN;
                            endcase
                        end
                    end
                end
                ST_FILL: begin
                    if (fill_take) begin
                        acc  <= fill_word;
                        bidx <= bidx + 1'b1;
                        if (have_bytes) bytes_left <= bytes_left - 1'b1;
                        if (bidx == LAST_BYTE) state <= ST_WBITS;
                    end
                end
                ST_DRAIN: begin
                    if (drain_step) begin
                        bidx <= bidx + 1'b1;
                        if (have_bytes) bytes_left <= bytes_left - 1'b1;
                        if (bidx == LAST_BYTE) begin
                            state <= (bytes_left > LEN_W'(1)) ? ST_RBITS : ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        cs_n_q <= 1'b1;
                        oe_q   <= 1'b0;
                        done_q <= 1'b1;
                        state  <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tick) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign wr_ready  = (state == ST_FILL) && have_bytes;
    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign bus_sck   = sck_q;
    assign bus_cs_n  = cs_n_q;
    assign bus_oe    = oe_q;
    assign bus_dout  = sh_msb;

endmodule

// File: rtl/spi3w_txn_checker.sv
// Protocol checker for the transaction master, bound to every instance.
// Observes ports only; holds no state of its own.
module spi3w_txn_checker (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic wr_valid,
    input logic wr_ready,
    input logic rd_valid,
    input logic rd_ready,
    input logic busy,
    input logic done,
    input logic bus_sck,
    input logic bus_cs_n,
    input logic bus_dout,
    input logic bus_oe
);

    // R2: the data line is steady across the high half of the bus clock
    a_r2_dout_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sck && $past(bus_sck)) |-> $stable(bus_dout));

    // R4 and R7: the line is never driven while deselected
    a_r7_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> !bus_oe);

    // R7: chip select rises only with the clock low
    a_r7_cs_rise_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> !bus_sck);

    // R7: no clock pulse outside a selected transaction
    a_r7_sck_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sck |-> !bus_cs_n);

    // R9: producer stall freezes the bus clock
    a_r9_wr_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && !wr_valid) |=> $stable(bus_sck));

    // R9: consumer stall freezes the bus clock
    a_r9_rd_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> $stable(bus_sck));

    // R10: done lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done coincides with chip select release
    a_r10_done_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(bus_cs_n));

    // R10: requests accepted only while idle
    a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !busy);

    // R11: reset puts the bus in its idle state
    a_r11_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (bus_cs_n && !bus_sck && !bus_oe && !busy));

endmodule

bind spi3w_txn_master spi3w_txn_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .busy      (busy),
    .done      (done),
    .bus_sck   (bus_sck),
    .bus_cs_n  (bus_cs_n),
    .bus_dout  (bus_dout),
    .bus_oe    (bus_oe)
);

// File: tb/spi3w_txn_master_tb.sv
// Vector-driven bench with a bit-level bus model and stream drivers.
module spi3w_txn_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 9;
    localparam int WATCHDOG   = 100000;
    localparam int CAPN       = 256;

    typedef struct packed {
        logic        wr;
        logic        inc;
        logic [1:0]  fn;
        logic [16:0] addr;
        logic [10:0] len;
        logic        swp;
        logic        stall;
        logic [7:0]  div;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b1, 2'd2, 17'h00123, 11'd8, 1'b0, 1'b0, 8'd1},
        '{1'b1, 1'b1, 2'd1, 17'h1ABCD, 11'd5, 1'b0, 1'b1, 8'd2},
        '{1'b0, 1'b1, 2'd0, 17'h00014, 11'd4, 1'b1, 1'b0, 8'd1},
        '{1'b0, 1'b1, 2'd1, 17'h00100, 11'd6, 1'b0, 1'b1, 8'd3},
        '{1'b0, 1'b0, 2'd2, 17'h0F0F0, 11'd3, 1'b0, 1'b0, 8'd1},
        '{1'b1, 1'b1, 2'd0, 17'h00018, 11'd4, 1'b1, 1'b0, 8'd1},
        '{1'b1, 1'b0, 2'd3, 17'h15555, 11'd0, 1'b0, 1'b0, 8'd2},
        '{1'b0, 1'b1, 2'd1, 17'h00040, 11'd0, 1'b0, 1'b0, 8'd1},
        '{1'b1, 1'b0, 2'd3, 17'h1FFFF, 11'd1, 1'b1, 1'b1, 8'd0}
    };

    logic        clk, rst_n;
    logic [7:0]  half_period;
    logic        req_valid, req_ready, req_write, req_incr, req_swap;
    logic [1:0]  req_func;
    logic [16:0] req_addr;
    logic [10:0] req_len;
    logic [7:0]  wr_data, rd_data;
    logic        wr_valid, wr_ready, rd_valid, rd_ready;
    logic        busy, done;
    logic        bus_sck, bus_cs_n, bus_dout, bus_oe, bus_din;

    spi3w_txn_master #(.DIV_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .half_period(half_period),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_incr(req_incr), .req_func(req_func), .req_addr(req_addr),
        .req_len(req_len), .req_swap(req_swap),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .busy(busy), .done(done),
        .bus_sck(bus_sck), .bus_cs_n(bus_cs_n), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .bus_din(bus_din)
    );

    int nchk = 0, nerr = 0, cyc = 0;
    int cur_idx = 0, cur_len = 0;
    logic cur_wr = 1'b0, cur_stall = 1'b0;
    int wr_k = 0, rd_n = 0, stall_seen = 0, stall_bad = 0;
    logic wr_take = 1'b0, rd_take = 1'b0;
    logic [7:0] rd_last;
    logic [7:0] rd_got [64];
    int nb_total = 0, base = 0;
    logic cap [CAPN];
    logic capoe [CAPN];
    time t_fall = 0, t_rise1 = 0, t_csrise = 0;

    function automatic logic [31:0] sw16(input logic [31:0] x);
        return {x[23:16], x[31:24], x[7:0], x[15:8]};
    endfunction

    function automatic logic [7:0] wbyte(input int idx, input int k);
        int t;
        t = k * 29 + idx * 7 + 3;
        return t[7:0];
    endfunction

    function automatic logic [7:0] rwire(input int idx, input int i);
        int t;
        t = i * 53 + 17 + idx * 11;
        return t[7:0];
    endfunction

    function automatic logic slave_bit(input int rel, input int idx);
        logic [7:0] b;
        b = rwire(idx, rel / 8);
        return b[7 - (rel % 8)];
    endfunction

    function automatic logic [31:0] capword(input int start);
        logic [31:0] w;
        for (int b = 0; b < 32; b++) w[31 - b] = (start + b < CAPN) ? cap[start + b] : 1'b0;
        return w;
    endfunction

    // bus model: serves read bits by position since chip select fell
    assign bus_din = slave_bit(nb_total - base, cur_idx);

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge bus_cs_n) begin
        base   = nb_total;
        t_fall = $time;
    end

    always @(posedge bus_cs_n) t_csrise = $time;

    always @(posedge bus_sck) begin
        int rel;
        rel = nb_total - base;
        if (rel == 0) t_rise1 = $time;
        if (rel < CAPN) begin
            cap[rel]   = bus_dout;
            capoe[rel] = bus_oe;
        end
        nb_total++;
    end

    // stream drivers and stall monitor, all away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (wr_take) wr_k++;
        if (rd_take) begin
            if (rd_n < 64) rd_got[rd_n] = rd_last;
            rd_n++;
        end
        if (req_valid && req_ready) begin
            wr_k = 0;
            rd_n = 0;
        end
        wr_valid = cur_wr && (wr_k < cur_len) && (!cur_stall || (cyc % 3 == 0));
        wr_data  = wbyte(cur_idx, wr_k);
        wr_take  = wr_valid && wr_ready;
        rd_ready = !cur_stall || (cyc % 2 == 0);
        rd_take  = rd_valid && rd_ready;
        rd_last  = rd_data;
        if ((wr_ready && !wr_valid) || (rd_valid && !rd_ready)) begin
            stall_seen++;
            if (bus_sck) stall_bad++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input int i, input int prev_hp);
        vec_t v;
        int hp, nbits, nwords, hdr, bad_oe;
        time prev_rise;
        logic [31:0] ew, gw, lw;
        v = VEC[i];
        hp = (v.div == 0) ? 1 : int'(v.div);
        prev_rise = t_csrise;
        @(negedge clk);
        cur_idx = i; cur_len = int'(v.len); cur_wr = v.wr; cur_stall = v.stall;
        half_period = v.div; req_write = v.wr; req_incr = v.inc; req_func = v.fn;
        req_addr = v.addr; req_len = v.len; req_swap = v.swp; req_valid = 1'b1;
        while (!req_ready && cyc < WATCHDOG) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && cyc < WATCHDOG) @(negedge clk);
        if (cyc >= WATCHDOG) begin
            chk(1'b0, "R10 watchdog expired waiting for done", 32'(cyc), 32'(WATCHDOG));
            return;
        end
        nwords = (int'(v.len) + 3) / 4;
        hdr    = (!v.wr && v.fn == 2'd1) ? 8 : 4;
        nbits  = 32 * nwords + hdr * 8;
        chk(nb_total - base == nbits,
            v.wr ? "R3 write bit count" : (v.fn == 2'd1 ? "R5 read bit count with turnaround word" : "R4 read bit count"),
            32'(nb_total - base), 32'(nbits));
        ew = {v.wr, v.inc, v.fn, v.addr, v.len};
        if (v.swp) ew = sw16(ew);
        chk(capword(0) == ew, v.swp ? "R6 swapped command word" : "R1 R2 command word", capword(0), ew);
        bad_oe = 0;
        for (int b = 0; b < nbits && b < CAPN; b++)
            if (capoe[b] !== ((b < 32) || v.wr)) bad_oe++;
        chk(bad_oe == 0, v.wr ? "R3 drive held through payload" : "R4 line turnaround", 32'(bad_oe), 32'd0);
        if (v.wr) begin
            for (int j = 0; j < nwords; j++) begin
                for (int m = 0; m < 4; m++)
                    lw[31 - 8 * m -: 8] = (4 * j + m < int'(v.len)) ? wbyte(i, 4 * j + m) : 8'h00;
                ew = v.swp ? sw16(lw) : lw;
                gw = capword(32 + 32 * j);
                chk(gw == ew, v.swp ? "R6 swapped write word" : "R3 write word with zero pad", gw, ew);
            end
        end else begin
            chk(rd_n == int'(v.len), "R4 read byte count", 32'(rd_n), 32'(v.len));
            for (int k = 0; k < int'(v.len) && k < rd_n; k++) begin
                int j, m;
                j = k / 4; m = k % 4;
                gw = {rwire(i, hdr + 4 * j), rwire(i, hdr + 4 * j + 1),
                      rwire(i, hdr + 4 * j + 2), rwire(i, hdr + 4 * j + 3)};
                lw = v.swp ? sw16(gw) : gw;
                chk(rd_got[k] == lw[31 - 8 * m -: 8],
                    v.swp ? "R6 swapped read byte" : (v.fn == 2'd1 ? "R5 read byte after turnaround" : "R4 read byte"),
                    32'(rd_got[k]), 32'(lw[31 - 8 * m -: 8]));
            end
        end
        chk(bus_cs_n && !bus_sck && !bus_oe, "R7 bus idle at done",
            {29'd0, bus_cs_n, bus_sck, bus_oe}, 32'h4);
        chk(t_rise1 - t_fall == time'(hp * CLK_PERIOD), "R8 first clock after one half-period",
            32'(t_rise1 - t_fall), 32'(hp * CLK_PERIOD));
        if (prev_hp > 0)
            chk(t_fall - prev_rise >= time'(prev_hp * CLK_PERIOD), "R8 chip select gap",
                32'(t_fall - prev_rise), 32'(prev_hp * CLK_PERIOD));
        chk(!req_ready && busy, "R10 not ready in closing gap", {30'd0, req_ready, busy}, 32'h1);
        @(negedge clk);
        chk(!done, "R10 done single pulse", 32'(done), 32'd0);
    endtask

    initial begin
        int prev_hp;
        rst_n = 1'b0; req_valid = 1'b0; half_period = 8'd1; req_write = 1'b0;
        req_incr = 1'b0; req_func = 2'd0; req_addr = '0; req_len = '0; req_swap = 1'b0;
        wr_valid = 1'b0; wr_data = '0; rd_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(bus_cs_n && !bus_sck && !bus_oe && !busy && !done, "R11 reset state",
            {27'd0, bus_cs_n, bus_sck, bus_oe, busy, done}, 32'h10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !busy, "R10 ready when idle", {30'd0, req_ready, busy}, 32'h2);

        prev_hp = 0;
        for (int i = 0; i < NVEC; i++) begin
            run_vec(i, prev_hp);
            prev_hp = (VEC[i].div == 0) ? 1 : int'(VEC[i].div);
        end

        chk(stall_seen > 0, "R9 stalls occurred", 32'(stall_seen), 32'd1);
        chk(stall_bad == 0, "R9 clock held low during stall", 32'(stall_bad), 32'd0);

        // reset in the middle of a write
        @(negedge clk);
        cur_idx = 0; cur_len = 8; cur_wr = 1'b1; cur_stall = 1'b0;
        half_period = 8'd2; req_write = 1'b1; req_func = 2'd2; req_len = 11'd8;
        req_swap = 1'b0; req_valid = 1'b1;
        while (!req_ready && cyc < WATCHDOG) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (40) @(negedge clk);
        chk(!bus_cs_n && busy, "R7 transaction in flight before reset",
            {30'd0, bus_cs_n, busy}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(bus_cs_n && !bus_sck && !bus_oe && !busy, "R11 reset mid transaction",
            {28'd0, bus_cs_n, bus_sck, bus_oe, busy}, 32'h8);
        @(negedge clk);
        rst_n = 1'b1;
        run_vec(0, 1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule